// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block is the slice of an SDRAM controller that runs a read followed by a write on the same data bus. A single request asks for one READ burst, tells the block how many of its data beats are actually wanted, and asks for a WRITE burst once those beats have arrived. The block issues READ, NOP and WRITE on the SDRAM command pins. It drives the DQM mask and the controller's own DQ output enable so that the SDRAM stops driving the bus before the controller starts. A WRITE may cut a READ burst short, or it may follow the last beat of a complete burst.

Read masking acts two clocks after DQM is sampled, while write masking acts in the same clock. The block therefore raises DQM two clocks before the truncating WRITE and keeps it high through the clock just before the WRITE. It then drops DQM on the WRITE clock so that every write beat is stored. An optional extra idle clock, set by a configuration input, widens the gap for systems whose drivers turn on before the SDRAM outputs release. CAS latency, burst length and the gap option are latched when a request is accepted. Request acceptance is held off until the write burst has finished.

Top module: `sdram_rw_turnaround`

## Requirements
- R1: While reset is asserted and after it, with no request, the command pins show NOP (`sd_cmd_n` = {cs_n, ras_n, cas_n, we_n} = 4'b0111), and `sd_dqm`, `dq_oe` and `rd_take` are low while `req_ready` is high.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) gives READ (4'b0101) in the next cycle, called cycle 0. `req_ready` stays low from cycle 0 until the sequence ends, and `req_valid` is ignored while `req_ready` is low, so no second READ appears.
- R3: CAS latency is 3 when `cfg_cas3` is 1 and 2 when it is 0. `rd_take` is high in exactly cycles CL to CL+K-1, where K is the number of wanted beats.
- R4: WRITE (4'b0100) appears exactly once, in cycle CL+K+G, where G is 1 when `cfg_extra_gap` is set and 0 otherwise.
- R5: When K is less than the burst length BL (truncation), `sd_dqm` is high in exactly cycles CL+K-2 through the cycle before the WRITE. This includes the clock just before the WRITE.
- R6: When K equals BL (a full burst, which always holds for BL = 1), `sd_dqm` stays low for the whole sequence.
- R7: BL is 1, 2, 4 or 8 for `cfg_burst_code` 0, 1, 2 or 3. `dq_oe` is high in exactly the BL cycles starting at the WRITE cycle, and `sd_dqm` is low in each of them.
- R8: In no cycle does `dq_oe` coincide with SDRAM read data that is driven and not masked. No unmasked read data appears at or after cycle CL+K.
- R9: A `req_keep_len` of 0, or one greater than BL, is treated as K = BL.
- R10: `req_ready` returns high in the cycle after the last write beat. Configuration inputs changed while `req_ready` is low do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request for a read burst followed by a write burst |
| req_ready | output | 1 | High when a request can be accepted |
| cfg_cas3 | input | 1 | CAS latency select: 1 for three clocks, 0 for two |
| cfg_burst_code | input | 2 | Burst length code: BL = 1 shifted left by the code |
| cfg_extra_gap | input | 1 | Adds one idle clock before the WRITE |
| req_keep_len | input | 4 | Number of wanted read beats K (0 or over BL means BL) |
| sd_cmd_n | output | 4 | SDRAM command pins {cs_n, ras_n, cas_n, we_n} |
| sd_dqm | output | 1 | SDRAM data mask |
| dq_oe | output | 1 | Controller DQ output enable |
| rd_take | output | 1 | Marks the cycles that carry wanted read data |

## Verification
The assertions assume that the configuration inputs and `req_keep_len` are valid whenever `req_valid` is high. They assume no mid-burst change is expected to take effect, and they rely on the internal truncation flag only being read while a sequence runs. The stimulus sets the configuration on the same cycle it raises `req_valid`, draws CAS, burst code, gap and length from the full legal ranges, and includes lengths of 0 and above BL. One directed sequence deliberately scrambles the configuration and holds `req_valid` high while busy, to show that those inputs are ignored. A behavioural data-bus model in the bench tracks the two-clock read mask and WRITE termination, and flags any bus overlap or any unwanted beat.

// File: rtl/sdram_rta_pkg.sv
// Package: shared command encoding and configuration decode helpers for the
// read-to-write turnaround sequencer. Assumes the usual active-low SDRAM
// command pins {cs_n, ras_n, cas_n, we_n}.
package sdram_rta_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sdr_op_e;

    localparam logic [3:0] PINS_NOP   = 4'b0111;
    localparam logic [3:0] PINS_READ  = 4'b0101;
    localparam logic [3:0] PINS_WRITE = 4'b0100;

    // Map an abstract operation to the command pin pattern.
    function automatic logic [3:0] op_to_pins(input sdr_op_e op);
        case (op)
            OP_READ:  return PINS_READ;
            OP_WRITE: return PINS_WRITE;
            default:  return PINS_NOP;
        endcase
    endfunction

endpackage

// File: rtl/rta_cfg_latch.sv
// Module: captures the configuration and wanted-beat count when a request
// is accepted and derives every cycle offset of the sequence from them.
// Assumes offsets are counted from the READ cycle (cycle 0) and that the
// captured values stay constant until the next load.
module rta_cfg_latch #(
    parameter int LEN_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             cas3,
    input  logic [1:0]       burst_code,
    input  logic             extra_gap,
    input  logic [LEN_W-1:0] keep_len,
    output logic [CNT_W-1:0] t_take_lo,
    output logic [CNT_W-1:0] t_take_hi,
    output logic [CNT_W-1:0] t_mask_lo,
    output logic [CNT_W-1:0] t_write,
    output logic [CNT_W-1:0] t_end,
    output logic             trunc
);

    logic             cas3_q;
    logic [1:0]       bcode_q;
    logic             gap_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] burst_len;
    logic [LEN_W-1:0] keep_eff;
    logic [CNT_W-1:0] cas_lat;

    // Capture the static settings on request acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas3_q  <= 1'b0;
            bcode_q <= 2'd0;
            gap_q   <= 1'b0;
            len_q   <= '0;
        end else if (load) begin
            cas3_q  <= cas3;
            bcode_q <= burst_code;
            gap_q   <= extra_gap;
            len_q   <= keep_len;
        end
    end

    // Derive burst length, wanted beats and every sequence offset.
    always_comb begin
        burst_len = LEN_W'(1) << bcode_q;
        keep_eff  = ((len_q == '0) || (len_q > burst_len)) ? burst_len : len_q;
        trunc     = (keep_eff < burst_len);
        cas_lat   = cas3_q ? CNT_W'(3) : CNT_W'(2);
        t_take_lo = cas_lat;
        t_take_hi = cas_lat + CNT_W'(keep_eff) - CNT_W'(1);
        t_mask_lo = cas_lat + CNT_W'(keep_eff) - CNT_W'(2);
        t_write   = cas_lat + CNT_W'(keep_eff) + CNT_W'(gap_q);
        t_end     = t_write + CNT_W'(burst_len) - CNT_W'(1);
    end

endmodule

// File: rtl/rta_seq_fsm.sv
// Module: idle/run control with a cycle counter that starts at 0 on the
// READ cycle and stops on the last write beat. Assumes t_end is stable
// while running.
module rta_seq_fsm #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] t_end,
    output logic             load,
    output logic             running,
    output logic [CNT_W-1:0] cnt
);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;
    st_e state;

    // Accept only when idle.
    always_comb load = req_valid && (state == ST_IDLE);

    assign running = (state == ST_RUN);

    // Step the sequence counter and return to idle after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (load) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else if (state == ST_RUN) begin
            if (cnt == t_end) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/rta_out_decode.sv
// Module: turns the cycle counter and the derived offsets into command pins,
// DQM, output enable and the wanted-data strobe. Assumes the offsets obey
// t_mask_lo < t_write <= t_end and that outputs are quiet while idle.
module rta_out_decode
    import sdram_rta_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] t_take_lo,
    input  logic [CNT_W-1:0] t_take_hi,
    input  logic [CNT_W-1:0] t_mask_lo,
    input  logic [CNT_W-1:0] t_write,
    input  logic             trunc,
    output logic [3:0]       cmd_n,
    output logic             dqm,
    output logic             oe,
    output logic             take
);

    sdr_op_e op;

    // Pick the command for this cycle.
    always_comb begin
        op = OP_NOP;
        if (running && cnt == '0)          op = OP_READ;
        else if (running && cnt == t_write) op = OP_WRITE;
        cmd_n = op_to_pins(op);
    end

    // Mask window before a truncating WRITE, then drive window for write data.
    always_comb begin
        dqm  = running && trunc && (cnt >= t_mask_lo) && (cnt < t_write);
        oe   = running && (cnt >= t_write);
        take = running && (cnt >= t_take_lo) && (cnt <= t_take_hi);
    end

endmodule

// File: rtl/sdram_rw_turnaround.sv
// Module: top of the read-to-write turnaround sequencer. One accepted
// request issues READ, waits for the wanted beats, masks the rest of the
// read burst through DQM (two-clock read latency), then issues WRITE with
// DQM low (zero-clock write latency) and enables the controller drivers for
// the write burst. Assumes configuration is valid when req_valid is high.
module sdram_rw_turnaround #(
    parameter int MAX_BL = 8,
    parameter int LEN_W  = $clog2(MAX_BL) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             cfg_cas3,
    input  logic [1:0]       cfg_burst_code,
    input  logic             cfg_extra_gap,
    input  logic [LEN_W-1:0] req_keep_len,
    output logic [3:0]       sd_cmd_n,
    output logic             sd_dqm,
    output logic             dq_oe,
    output logic             rd_take
);

    localparam int MAX_END = 3 + 2 * MAX_BL;
    localparam int CNT_W   = $clog2(MAX_END + 1);

    logic             load;
    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] t_take_lo, t_take_hi, t_mask_lo, t_write, t_end;
    logic             cfg_trunc;

    rta_cfg_latch #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cas3       (cfg_cas3),
        .burst_code (cfg_burst_code),
        .extra_gap  (cfg_extra_gap),
        .keep_len   (req_keep_len),
        .t_take_lo  (t_take_lo),
        .t_take_hi  (t_take_hi),
        .t_mask_lo  (t_mask_lo),
        .t_write    (t_write),
        .t_end      (t_end),
        .trunc      (cfg_trunc)
    );

    rta_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .t_end     (t_end),
        .load      (load),
        .running   (running),
        .cnt       (cnt)
    );

    rta_out_decode #(.CNT_W(CNT_W)) u_dec (
        .running   (running),
        .cnt       (cnt),
        .t_take_lo (t_take_lo),
        .t_take_hi (t_take_hi),
        .t_mask_lo (t_mask_lo),
        .t_write   (t_write),
        .trunc     (cfg_trunc),
        .cmd_n     (sd_cmd_n),
        .dqm       (sd_dqm),
        .oe        (dq_oe),
        .take      (rd_take)
    );

    assign req_ready = !running;

endmodule

// File: rtl/sdram_rw_turnaround_chk.sv
// Checker: temporal properties of the turnaround sequencer, bound to the top.
// Assumes it sees the truncation flag of the latched configuration.
module sdram_rw_turnaround_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] sd_cmd_n,
    input logic       sd_dqm,
    input logic       dq_oe,
    input logic       trunc
);

    // R2: an accepted request yields READ next cycle.
    a_r2_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (sd_cmd_n == 4'b0101));

    // R1/R2: nothing is issued or driven while idle.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sd_cmd_n == 4'b0111 && !sd_dqm && !dq_oe));

    // R7: write beats are never masked.
    a_r7_oe_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !sd_dqm);

    // R7: the drive window opens on the WRITE cycle.
    a_r7_oe_starts_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (sd_cmd_n == 4'b0100));

    // R5: DQM is high on the clock before a truncating WRITE.
    a_r5_mask_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd_n == 4'b0100 && trunc) |-> $past(sd_dqm));

    // R6: a full burst never raises DQM.
    a_r6_no_mask_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!trunc && !req_ready) |-> !sd_dqm);

    // R10: ready returns as the drive window closes.
    a_r10_ready_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> req_ready);

endmodule

bind sdram_rw_turnaround sdram_rw_turnaround_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sd_cmd_n  (sd_cmd_n),
    .sd_dqm    (sd_dqm),
    .dq_oe     (dq_oe),
    .trunc     (cfg_trunc)
);

// File: tb/sdram_rw_turnaround_bench.sv
module sdram_rw_turnaround_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       cfg_cas3 = 1'b0;
    logic [1:0] cfg_burst_code = 2'd0;
    logic       cfg_extra_gap = 1'b0;
    logic [3:0] req_keep_len = 4'd0;
    logic [3:0] sd_cmd_n;
    logic       sd_dqm;
    logic       dq_oe;
    logic       rd_take;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [3:0] NOP_P = 4'b0111;
    localparam logic [3:0] RD_P  = 4'b0101;
    localparam logic [3:0] WR_P  = 4'b0100;

    always #2 clk = ~clk;

    sdram_rw_turnaround u_sdram_rw_turnaround (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .cfg_cas3       (cfg_cas3),
        .cfg_burst_code (cfg_burst_code),
        .cfg_extra_gap  (cfg_extra_gap),
        .req_keep_len   (req_keep_len),
        .sd_cmd_n       (sd_cmd_n),
        .sd_dqm         (sd_dqm),
        .dq_oe          (dq_oe),
        .rd_take        (rd_take)
    );

    function automatic int exp_keep(input int len, input int bl);
        return (len == 0 || len > bl) ? bl : len;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one read-then-write sequence and compare every cycle with the model.
    task automatic run_txn(input bit cas3, input int bcode, input bit gap,
                           input int len, input bit disturb);
        int cl, bl, k, tw, mlo, tend, wc;
        bit tr;
        bit dq_hist [0:31];
        int e2 = 0, a2 = 0, x2 = 0;
        int e3 = 0, a3 = 0, x3 = 0;
        int e4 = 0, a4 = 0, x4 = 0;
        int e5 = 0, a5 = 0, x5 = 0;
        int e7 = 0, a7 = 0, x7 = 0;
        int e8 = 0, a8 = 0;
        cl = cas3 ? 3 : 2;
        bl = 1 << bcode;
        k = exp_keep(len, bl);
        tr = (k < bl);
        tw = cl + k + (gap ? 1 : 0);
        mlo = cl + k - 2;
        tend = tw + bl - 1;
        wc = 99;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready before request", int'(req_ready), 1);
        cfg_cas3 = cas3; cfg_burst_code = 2'(bcode);
        cfg_extra_gap = gap; req_keep_len = 4'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c <= tend; c++) begin
            bit exp_dqm, exp_oe, exp_take, drv;
            logic [3:0] exp_cmd;
            if (c != 0) @(negedge clk);
            exp_cmd  = (c == 0) ? RD_P : (c == tw) ? WR_P : NOP_P;
            exp_dqm  = tr && c >= mlo && c < tw;
            exp_oe   = c >= tw;
            exp_take = c >= cl && c <= cl + k - 1;
            dq_hist[c] = sd_dqm;
            if ((c == 0 && sd_cmd_n != RD_P) || (c > 0 && sd_cmd_n == RD_P) || req_ready) begin
                if (e2 == 0) begin a2 = int'(sd_cmd_n); x2 = int'(exp_cmd); end
                e2++;
            end
            if (rd_take != exp_take) begin
                if (e3 == 0) begin a3 = c; x3 = int'(exp_take); end
                e3++;
            end
            if ((sd_cmd_n == WR_P) != (c == tw)) begin
                if (e4 == 0) begin a4 = c; x4 = tw; end
                e4++;
            end
            if (sd_dqm != exp_dqm) begin
                if (e5 == 0) begin a5 = c; x5 = int'(exp_dqm); end
                e5++;
            end
            if (dq_oe != exp_oe || (dq_oe && sd_dqm)) begin
                if (e7 == 0) begin a7 = c; x7 = int'(exp_oe); end
                e7++;
            end
            // Behavioural bus: WRITE ends the read burst; DQM masks two clocks later.
            if (sd_cmd_n == WR_P && wc == 99) begin
                wc = c;
                if (c <= cl + bl - 1 && (c == 0 || !dq_hist[c-1])) begin
                    if (e5 == 0) begin a5 = c; x5 = 1; end
                    e5++;
                end
            end
            drv = (c >= cl) && (c <= cl + bl - 1) && (c < wc) && !(c >= 2 && dq_hist[c-2]);
            if (drv && (dq_oe || c >= cl + k)) begin
                if (e8 == 0) a8 = c;
                e8++;
            end
            if (disturb && c == 0) begin
                req_valid = 1'b1;
                cfg_cas3 = ~cas3; cfg_burst_code = ~2'(bcode);
                cfg_extra_gap = ~gap; req_keep_len = 4'd1;
            end
            if (disturb && c == 1) req_valid = 1'b0;
        end
        @(negedge clk);
        check(req_ready == 1'b1 && sd_cmd_n == NOP_P && !dq_oe, "R10 ready after last beat",
              int'(req_ready), 1);
        check(e2 == 0, "R2 single READ and busy", a2, x2);
        check(e3 == 0, "R3 wanted-data strobe cycle", a3, x3);
        check(e4 == 0, "R4 WRITE cycle", a4, x4);
        if (tr) check(e5 == 0, "R5 truncation DQM window", a5, x5);
        else    check(e5 == 0, "R6 full burst DQM low", a5, x5);
        check(e7 == 0, "R7 drive window", a7, x7);
        check(e8 == 0, "R8 bus contention or unwanted beat", a8, -1);
        if (len == 0 || len > bl)
            check(e3 == 0 && e4 == 0, "R9 length clamp to burst", a4, x4);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(sd_cmd_n == NOP_P && !sd_dqm && !dq_oe && !rd_take && req_ready,
              "R1 reset outputs", int'(sd_cmd_n), int'(NOP_P));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sd_cmd_n == NOP_P && !sd_dqm && !dq_oe && req_ready,
              "R1 idle after reset", int'(sd_cmd_n), int'(NOP_P));
        // Directed corner cases.
        run_txn(1'b1, 3, 1'b0, 3, 1'b0);  // R5 truncation, CL3 BL8
        run_txn(1'b1, 3, 1'b1, 3, 1'b0);  // R4 extra gap
        run_txn(1'b0, 1, 1'b0, 1, 1'b0);  // R5 tightest mask start, CL2
        run_txn(1'b0, 2, 1'b0, 4, 1'b0);  // R6 full burst
        run_txn(1'b1, 0, 1'b1, 1, 1'b0);  // R6 burst of one
        run_txn(1'b0, 3, 1'b0, 0, 1'b0);  // R9 zero length
        run_txn(1'b1, 2, 1'b0, 12, 1'b0); // R9 length above burst
        run_txn(1'b1, 3, 1'b0, 2, 1'b1);  // R10 config change while busy
        // Constrained random sequences.
        for (int i = 0; i < 60; i++) begin
            int bc;
            bc = int'($urandom_range(3, 0));
            run_txn(1'($urandom_range(1, 0)), bc, 1'($urandom_range(1, 0)),
                    int'($urandom_range(9, 0)), 1'($urandom_range(7, 0) == 0));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule